// File: doc/BRIEF.md
# Serial line baud lock detector

The block locks a node with an imprecise local oscillator onto the bit rate of a serial bus. Once armed it waits for the line to stay idle high for a set time. It then times an eleven-bit synchronisation frame: a low start bit, eight data bits that alternate between 1 and 0 starting with 1, a parity bit of 1 and a stop bit of 1. Each low or high cell is compared with the cell before it. When the frame is accepted, the block loads a baud constant into its output register and signals completion.

The baud constant is an unsigned 12.4 fixed-point count of clock cycles per bit. It is sixteen times the mean length of the eight data cells. That equals the sum of those cells shifted left by one, so no divider is needed. A receiver and a transmitter next to the block stay idle while `busy_o` is high. A rejected frame sets a sticky error flag and the block goes back to waiting for silence, still busy, so that it can lock on a later frame.

Top module: `sbd_baud_sync`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are 0, and `baud_o` equals the parameter INIT_BAUD (default 256).
- R2: The block samples `arm_i` high while it is not busy. From the next cycle `busy_o` is 1 and both `done_o` and `err_o` are 0. An `arm_i` pulse while `busy_o` is 1 has no effect on any output.
- R3: While armed, a falling edge starts a measurement only if at least QUIET_LEN (default 1024) consecutive high samples came before it. An edge with less silence before it is ignored: `done_o` and `err_o` stay 0.
- R4: On acceptance, `baud_o` becomes twice the sum of the eight data-cell lengths in clock cycles (16 × cell length for a uniform frame). In the same cycle `done_o` rises and `busy_o` falls. This happens exactly L8 + floor(L8/2) cycles after the cycle in which the rise after the last data bit is sampled, where L8 is the length of the last data cell.
- R5: A cell is rejected when 25 × |cur − prev| > prev, where cur is its length and prev is the length of the cell before it. Equality is accepted. A reject sets `err_o`, keeps `busy_o` at 1 and leaves `baud_o` unchanged.
- R6: After the last data cell the line must stay high for L8 + floor(L8/2) cycles. A low sample before that rejects the frame.
- R7: A cell that lasts 2^CELL_W − 1 cycles (4095 by default) is rejected.
- R8: A start cell shorter than MIN_CELL (default 8) cycles is rejected.
- R9: After a reject, `err_o` stays 1 until the next accepted arm. The block waits for silence again, and a later valid frame still locks with `err_o` left at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Filtered, synchronised serial line, idle high |
| arm_i | input | 1 | Start a synchronisation attempt |
| busy_o | output | 1 | Attempt in progress; normal traffic held off |
| done_o | output | 1 | Last attempt locked; cleared by arm |
| err_o | output | 1 | Sticky reject flag; cleared by arm |
| baud_o | output | CELL_W+4 | Cycles per bit, 12.4 fixed point |

## Verification
`busy_o` and the cleared flags are due one clock after `arm_i` is sampled. A reject shows on `err_o` one clock after the offending line sample. The lock result on `done_o` and `baud_o` is due exactly L8 + floor(L8/2) clocks after the final rising edge is sampled. The bench drives every line transition on the falling clock edge and counts clocks from that edge. For one directed frame it checks that `done_o` is still 0 one cycle before the due clock and is 1 at the due clock. The other frames are checked after a margin of twice the last cell length. Reject and ignore cases are judged from the flags and from an unchanged `baud_o`.

// File: rtl/sbd_pkg.sv
// Shared types for the baud lock detector.
// Assumes a frame of start + 8 alternating data cells, then a high tail.
package sbd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_QUIET,
        ST_CELLS,
        ST_TAIL
    } sbd_state_e;

    // start cell plus eight data cells
    localparam int unsigned NUM_CELLS = 9;
endpackage

// File: rtl/sbd_quiet.sv
// Counts consecutive high samples of the line and reports when the required
// silence has been seen. Assumes rx_i is already synchronised.
module sbd_quiet #(
    parameter int QUIET_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic rx_i,
    output logic quiet_o
);
    localparam int QW = $clog2(QUIET_LEN + 1);
    localparam logic [QW-1:0] LIM = QW'(QUIET_LEN);

    logic [QW-1:0] cnt;

    // saturating run-length counter of high samples
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !rx_i) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign quiet_o = (cnt == LIM);

    // silence can only be reported when the last sample was high
    assert_quiet_after_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_o |-> $past(rx_i));
endmodule

// File: rtl/sbd_cell_timer.sv
// Cycle counter for one line cell. Restart loads 1 (the edge cycle itself),
// the count saturates at all ones and reports expiry there.
module sbd_cell_timer #(
    parameter int CELL_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    output logic [CELL_W-1:0] cnt_o,
    output logic              expired_o
);
    localparam logic [CELL_W-1:0] MAX = '1;

    // count cycles since the last restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (restart_i) begin
            cnt_o <= CELL_W'(1);
        end else if (!run_i) begin
            cnt_o <= '0;
        end else if (cnt_o != MAX) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    assign expired_o = (cnt_o == MAX);

    // expiry needs the timer to have been running
    assert_expiry_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> $past(run_i) || $past(restart_i));
endmodule

// File: rtl/sbd_tol_check.sv
// Combinational tolerance test: passes when TOL_DIV * |cur - ref| <= ref.
// With TOL_DIV = 25 this is a 4 percent window relative to the earlier cell.
module sbd_tol_check #(
    parameter int CELL_W  = 12,
    parameter int TOL_DIV = 25
) (
    input  logic [CELL_W-1:0] cur_i,
    input  logic [CELL_W-1:0] ref_i,
    output logic              ok_o
);
    localparam int MW = CELL_W + $clog2(TOL_DIV) + 1;

    logic [CELL_W-1:0] diff;
    logic [MW-1:0]     scaled;

    // absolute difference scaled by the tolerance divisor
    always_comb begin
        diff   = (cur_i > ref_i) ? (cur_i - ref_i) : (ref_i - cur_i);
        scaled = MW'(diff) * MW'(TOL_DIV);
        ok_o   = (scaled <= MW'(ref_i));
    end
endmodule

// File: rtl/sbd_baud_sync.sv
// Baud lock detector top. Armed by arm_i, waits for line silence, times the
// start cell and eight alternating data cells, checks each against the one
// before, checks the high tail, then loads 2 * sum(data cells) as a 12.4
// cycles-per-bit constant. Assumes rx_i is filtered and synchronised.
module sbd_baud_sync
    import sbd_pkg::*;
#(
    parameter int CELL_W    = 12,
    parameter int QUIET_LEN = 1024,
    parameter int MIN_CELL  = 8,
    parameter int TOL_DIV   = 25,
    parameter int INIT_BAUD = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_i,
    input  logic                arm_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [CELL_W+3:0]   baud_o
);
    localparam int BAUD_W = CELL_W + 4;
    localparam int SUM_W  = CELL_W + 3;
    localparam int IDX_W  = $clog2(NUM_CELLS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CELLS - 1);

    sbd_state_e        state;
    logic [IDX_W-1:0]  cell_idx;
    logic [CELL_W-1:0] prev_len;
    logic [SUM_W-1:0]  sum_q;
    logic              done_q, err_q;
    logic [BAUD_W-1:0] baud_q;

    logic              quiet;
    logic [CELL_W-1:0] cnt;
    logic              expired;
    logic              tol_ok;
    logic              edge_seen;
    logic              cell_bad;
    logic              go_cells;
    logic [CELL_W:0]   tail_lim;

    // the start cell is low, data cells alternate starting high
    assign edge_seen = (state == ST_CELLS) && (rx_i != cell_idx[0]);
    assign go_cells  = (state == ST_QUIET) && quiet && !rx_i;
    assign cell_bad  = (cell_idx == '0) ? (cnt < CELL_W'(MIN_CELL)) : !tol_ok;
    assign tail_lim  = {1'b0, prev_len} + {2'b00, prev_len[CELL_W-1:1]};

    sbd_quiet #(.QUIET_LEN(QUIET_LEN)) quiet_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state != ST_QUIET),
        .rx_i    (rx_i),
        .quiet_o (quiet)
    );

    sbd_cell_timer #(.CELL_W(CELL_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     ((state == ST_CELLS) || (state == ST_TAIL)),
        .restart_i (go_cells || edge_seen),
        .cnt_o     (cnt),
        .expired_o (expired)
    );

    sbd_tol_check #(.CELL_W(CELL_W), .TOL_DIV(TOL_DIV)) tol_i (
        .cur_i (cnt),
        .ref_i (prev_len),
        .ok_o  (tol_ok)
    );

    // sequence control, measurement bookkeeping and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cell_idx <= '0;
            prev_len <= '0;
            sum_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            baud_q   <= BAUD_W'(INIT_BAUD);
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (arm_i) begin
                        state  <= ST_QUIET;
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                    end
                end
                ST_QUIET: begin
                    if (go_cells) begin
                        state    <= ST_CELLS;
                        cell_idx <= '0;
                        sum_q    <= '0;
                    end
                end
                ST_CELLS: begin
                    if (expired || (edge_seen && cell_bad)) begin
                        state <= ST_QUIET;
                        err_q <= 1'b1;
                    end else if (edge_seen) begin
                        prev_len <= cnt;
                        if (cell_idx != '0) begin
                            sum_q <= sum_q + SUM_W'(cnt);
                        end
                        if (cell_idx == LAST_IDX) begin
                            state <= ST_TAIL;
                        end else begin
                            cell_idx <= cell_idx + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (expired || !rx_i) begin
                        state <= ST_QUIET;
                        err_q <= 1'b1;
                    end else if ({1'b0, cnt} == tail_lim) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        baud_q <= {sum_q, 1'b0};
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state != ST_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;
    assign baud_o = baud_q;

    assert_arm_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && arm_i) |=> (busy_o && !done_o && !err_o));

    assert_lock_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));

    assert_baud_moves_on_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(baud_o) |-> $rose(done_o));

    assert_reject_keeps_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> busy_o);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(arm_i && !busy_o)) |=> err_o);
endmodule

// File: tb/sbd_baud_sync_tb.sv
module sbd_baud_sync_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QUIET      = 1024;
    localparam int MINC       = 8;
    localparam int IDLE_GAP   = QUIET + 76;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic        arm = 1'b0;
    logic        busy, done, err;
    logic [15:0] baud;

    int n_chk = 0;
    int n_fail = 0;
    int cells [9];
    int exp_baud = 256;
    int exp_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sbd_baud_sync dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx),
        .arm_i  (arm),
        .busy_o (busy),
        .done_o (done),
        .err_o  (err),
        .baud_o (baud)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_pulse();
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // drive start + eight data cells; the line is left high afterwards
    task automatic drive_cells();
        for (int k = 0; k < 9; k++) begin
            rx = k[0];
            tick(cells[k]);
        end
        rx = 1'b1;
    endtask

    task automatic fill_uniform(input int len);
        for (int k = 0; k < 9; k++) cells[k] = len;
    endtask

    function automatic int frame_ok();
        int d;
        if (cells[0] < MINC) return 0;
        for (int k = 0; k < 9; k++) if (cells[k] >= 4095) return 0;
        for (int k = 1; k < 9; k++) begin
            d = cells[k] - cells[k-1];
            if (d < 0) d = -d;
            if (25 * d > cells[k-1]) return 0;
        end
        return 1;
    endfunction

    function automatic int frame_baud();
        int s = 0;
        for (int k = 1; k < 9; k++) s += cells[k];
        return 2 * s;
    endfunction

    // full frame with idle lead-in and a tail margin; checks the outcome
    task automatic run_frame(input string tag);
        int ok;
        ok = frame_ok();
        tick(IDLE_GAP);
        drive_cells();
        tick(2 * cells[8] + 4);
        if (ok != 0) begin
            exp_baud = frame_baud();
            check({tag, " done"}, int'(done), 1);
            check({tag, " busy"}, int'(busy), 0);
        end else begin
            exp_err = 1;
            check({tag, " done"}, int'(done), 0);
            check({tag, " busy"}, int'(busy), 1);
        end
        check({tag, " err"}, int'(err), exp_err);
        check({tag, " baud"}, int'(baud), exp_baud);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t;
        int w;
        void'($urandom(32'd20240611));
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 err", int'(err), 0);
        check("R1 baud", int'(baud), 256);

        // R2 arm
        arm_pulse();
        check("R2 busy after arm", int'(busy), 1);

        // R3 too little silence: frame ignored
        tick(200);
        fill_uniform(30);
        drive_cells();
        tick(300);
        check("R3 done", int'(done), 0);
        check("R3 err", int'(err), 0);
        check("R3 busy", int'(busy), 1);

        // R4 exact lock cycle, uniform cells of 30
        tick(IDLE_GAP);
        drive_cells();
        t = 30 + 15;
        tick(t);
        check("R4 done one early", int'(done), 0);
        tick(1);
        check("R4 done due", int'(done), 1);
        check("R4 busy due", int'(busy), 0);
        check("R4 baud", int'(baud), 480);
        exp_baud = 480;

        // R8 short start cell, then R2 arm while busy is ignored
        arm_pulse();
        check("R2 done cleared", int'(done), 0);
        fill_uniform(30);
        cells[0] = 5;
        run_frame("R8 short start");
        arm_pulse();
        check("R2 arm while busy err", int'(err), 1);
        check("R2 arm while busy busy", int'(busy), 1);
        check("R2 arm while busy baud", int'(baud), exp_baud);

        // R5 boundary accepted, R9 err stays set after relock
        fill_uniform(26);
        cells[0] = 25;
        cells[1] = 25;
        run_frame("R5 R9 boundary");
        check("R5 boundary baud", int'(baud), 414);

        // R5 tolerance reject
        arm_pulse();
        check("R2 err cleared", int'(err), 0);
        exp_err = 0;
        fill_uniform(27);
        cells[0] = 25;
        cells[1] = 25;
        run_frame("R5 reject");
        fill_uniform(50);
        run_frame("R9 relock");

        // R6 tail too short
        arm_pulse();
        exp_err = 0;
        fill_uniform(40);
        tick(IDLE_GAP);
        drive_cells();
        tick(40);
        rx = 1'b0;
        tick(20);
        rx = 1'b1;
        tick(5);
        check("R6 err", int'(err), 1);
        check("R6 done", int'(done), 0);
        check("R6 baud", int'(baud), exp_baud);
        exp_err = 1;
        fill_uniform(33);
        run_frame("R6 relock");

        // R7 cell timeout
        arm_pulse();
        exp_err = 0;
        tick(IDLE_GAP);
        rx = 1'b0;
        tick(4200);
        rx = 1'b1;
        check("R7 err", int'(err), 1);
        check("R7 busy", int'(busy), 1);
        check("R7 baud", int'(baud), exp_baud);
        exp_err = 1;
        fill_uniform(45);
        run_frame("R7 relock");

        // random frames, mostly within tolerance (R4 R5 R9)
        for (int it = 0; it < 30; it++) begin
            if (!busy) begin
                arm_pulse();
                exp_err = 0;
            end
            cells[0] = 20 + int'($urandom_range(40));
            for (int k = 1; k < 9; k++) begin
                w = cells[k-1] / 25;
                if ($urandom_range(99) < 85) begin
                    cells[k] = cells[k-1] + int'($urandom_range(2 * w)) - w;
                end else if ($urandom_range(1) == 1) begin
                    cells[k] = cells[k-1] + w + 1 + int'($urandom_range(3));
                end else begin
                    cells[k] = cells[k-1] - w - 1 - int'($urandom_range(3));
                end
            end
            run_frame("R4 R5 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule